// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block controls the power state of an always-on domain that runs from the slow real-time clock. Software writes a command register to put the system to sleep. The block then drops its power-enable output and watches a wakeup pin. The pin only counts once it has stayed high for a programmed number of ticks. A shorter pulse is treated as a glitch: the qualification count starts again from zero and the system stays asleep.

Once a wakeup is accepted, power comes back and an active-low reset output is held low for a second programmed number of ticks. After that the block is awake again. Both tick counts are programmed in steps of 32, through fields that sit at bit 5 and above of their registers. A count of zero means instant qualification for the filter, and no reset pulse at all for the reset counter.

The registers are reached over a plain 32-bit register bus. Reads are combinational from the address. Writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `hib_seq_top`

## Requirements
- R1: After reset the state code is 0 (awake), `pwr_en` is 1, `rst_n_out` is 1, and the filter and reset-count registers read 0.
- R2: A write to offset 0x20 with data bit 0 set, made while awake, makes `pwr_en` low after that edge. Reading offset 0x20 returns the state code in bits 2:0: 0 awake, 1 asleep, 2 qualifying the pin, 3 reset pulse. All other bits read as 0.
- R3: A write to 0x20 with bit 0 clear is ignored. So is any write to 0x20 made while the state is not awake, including a write on the last edge of the reset pulse.
- R4: The filter register at 0x24 keeps only write-data bits 15:5. Reads return those bits in place and 0 elsewhere. The filter tick count F is the stored value as read, for example 0xFFFFFFFF reads back as 0xFFE0.
- R5: While asleep, a wakeup is accepted after the pin has been sampled high on F consecutive clock edges, or on one edge when F is 0. `pwr_en` is high from the edge that accepts it.
- R6: If the pin is sampled low while qualifying, the state returns to asleep (code 1), `pwr_en` stays low, and a later wakeup again needs F consecutive high samples.
- R7: The reset-count register at 0x28 keeps only write-data bits 11:5, read back in place. For example 0xFFFFFFFF reads as 0x0FE0. The stored value is the pulse length R. After an accepted wakeup with R nonzero, `rst_n_out` is low for exactly R cycles while `pwr_en` is high, and then the state is awake.
- R8: With R equal to 0, an accepted wakeup goes straight to awake, and `rst_n_out` never goes low.
- R9: The wakeup pin has no effect while awake: `pwr_en` and `rst_n_out` stay high.
- R10: Reads from offsets other than 0x20, 0x24 and 0x28 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wake_pin | input | 1 | Wakeup request, active high, already synchronous to clk |
| pwr_en | output | 1 | Power enable, low while asleep or qualifying |
| rst_n_out | output | 1 | Active-low reset, low during the reset pulse |

## Verification
Two events can land on the same clock edge: the end of the reset pulse and a new sleep command. The bench times a write to 0x20 so that it is sampled on the final edge of the pulse. It then requires the block to come out awake, with `pwr_en` and `rst_n_out` high and a state code of 0, because the command arrived while the state was not yet awake. A second coincidence is checked too. The pin is dropped for a single sample in the middle of qualification, which must send the state back to asleep. The bench then confirms that the full filter count is needed again.

// File: rtl/hib_seq_pkg.sv
package hib_seq_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int FIELD_LSB = 5;
    localparam int FILT_MSB  = 15;
    localparam int RCNT_MSB  = 11;
    localparam int CNT_W     = FILT_MSB + 1;

    localparam logic [ADDR_W-1:0] OFF_SLEEP = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_FILT  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_RCNT  = 8'h28;

    typedef enum logic [2:0] {
        ST_AWAKE  = 3'd0,
        ST_ASLEEP = 3'd1,
        ST_QUAL   = 3'd2,
        ST_PULSE  = 3'd3
    } seq_state_e;

    typedef struct packed {
        logic             sleep_req;
        logic [CNT_W-1:0] filt_ticks;
        logic [CNT_W-1:0] pulse_ticks;
    } seq_cfg_t;

    function automatic logic power_off(input seq_state_e s);
        return (s == ST_ASLEEP) || (s == ST_QUAL);
    endfunction

endpackage

// File: rtl/hib_seq_regs.sv
module hib_seq_regs
    import hib_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  seq_state_e        cur_state,
    output logic [DATA_W-1:0] bus_rdata,
    output seq_cfg_t          cfg
);
    localparam int FILT_BITS = FILT_MSB - FIELD_LSB + 1;
    localparam int RCNT_BITS = RCNT_MSB - FIELD_LSB + 1;

    logic [FILT_BITS-1:0] filt_field;
    logic [RCNT_BITS-1:0] rcnt_field;
    logic                 wr_en;
    logic                 unused_wdata_bits;

    assign wr_en = bus_sel && bus_wr;
    assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:FILT_MSB+1], bus_wdata[FIELD_LSB-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_field <= '0;
            rcnt_field <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFF_FILT)
                filt_field <= bus_wdata[FILT_MSB:FIELD_LSB];
            if (bus_addr == OFF_RCNT)
                rcnt_field <= bus_wdata[RCNT_MSB:FIELD_LSB];
        end
    end

    always_comb begin
        cfg.sleep_req   = wr_en && (bus_addr == OFF_SLEEP) && bus_wdata[0];
        cfg.filt_ticks  = {filt_field, {FIELD_LSB{1'b0}}};
        cfg.pulse_ticks = CNT_W'({rcnt_field, {FIELD_LSB{1'b0}}});
    end

    always_comb begin
        case (bus_addr)
            OFF_SLEEP: bus_rdata = DATA_W'(cur_state);
            OFF_FILT:  bus_rdata = DATA_W'(cfg.filt_ticks);
            OFF_RCNT:  bus_rdata = DATA_W'(cfg.pulse_ticks);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hib_seq_fsm.sv
module hib_seq_fsm
    import hib_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_cfg_t   cfg,
    input  logic       wake_pin,
    output seq_state_e state
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] tick_inc;
    logic             filt_short;
    logic             pulse_none;

    assign tick_inc   = tick_cnt + ONE;
    assign filt_short = (cfg.filt_ticks <= ONE);
    assign pulse_none = (cfg.pulse_ticks == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_AWAKE;
            tick_cnt <= '0;
        end else begin
            case (state)
                ST_AWAKE: begin
                    tick_cnt <= '0;
                    if (cfg.sleep_req)
                        state <= ST_ASLEEP;
                end
                ST_ASLEEP: begin
                    tick_cnt <= '0;
                    if (wake_pin) begin
                        if (filt_short) begin
                            state <= pulse_none ? ST_AWAKE : ST_PULSE;
                        end else begin
                            state    <= ST_QUAL;
                            tick_cnt <= ONE;
                        end
                    end
                end
                ST_QUAL: begin
                    if (!wake_pin) begin
                        state    <= ST_ASLEEP;
                        tick_cnt <= '0;
                    end else if (tick_inc == cfg.filt_ticks) begin
                        state    <= pulse_none ? ST_AWAKE : ST_PULSE;
                        tick_cnt <= '0;
                    end else begin
                        tick_cnt <= tick_inc;
                    end
                end
                ST_PULSE: begin
                    if (tick_inc >= cfg.pulse_ticks) begin
                        state    <= ST_AWAKE;
                        tick_cnt <= '0;
                    end else begin
                        tick_cnt <= tick_inc;
                    end
                end
                default: begin
                    state    <= ST_AWAKE;
                    tick_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/hib_seq_outdec.sv
module hib_seq_outdec
    import hib_seq_pkg::*;
(
    input  seq_state_e state,
    output logic       pwr_en,
    output logic       rst_n_out
);
    always_comb begin
        pwr_en    = !power_off(state);
        rst_n_out = (state != ST_PULSE);
    end
endmodule

// File: rtl/hib_seq_top.sv
module hib_seq_top
    import hib_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        wake_pin,
    output logic        pwr_en,
    output logic        rst_n_out
);
    seq_state_e cur_state;
    seq_cfg_t   cfg;

    hib_seq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cur_state (cur_state),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    hib_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .wake_pin (wake_pin),
        .state    (cur_state)
    );

    hib_seq_outdec u_out (
        .state     (cur_state),
        .pwr_en    (pwr_en),
        .rst_n_out (rst_n_out)
    );

endmodule

// File: rtl/hib_seq_checker.sv
module hib_seq_checker
    import hib_seq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        wake_pin,
    input logic        pwr_en,
    input logic        rst_n_out,
    input seq_state_e  cur_state,
    input logic [15:0] pulse_ticks
);
    logic sleep_wr;
    assign sleep_wr = bus_sel && bus_wr && (bus_addr == OFF_SLEEP) && bus_wdata[0];

    AST_SLEEP_DROPS_POWER: assert property (@(posedge clk) disable iff (rst)
        (sleep_wr && cur_state == ST_AWAKE) |=> !pwr_en); // R2

    AST_AWAKE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_AWAKE && !sleep_wr) |=> (pwr_en && rst_n_out)); // R9

    AST_NO_WAKE_WITHOUT_PIN: assert property (@(posedge clk) disable iff (rst)
        (!pwr_en && !wake_pin) |=> !pwr_en); // R5

    AST_GLITCH_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_QUAL && !wake_pin) |=> (cur_state == ST_ASLEEP)); // R6

    AST_PULSE_AFTER_SLEEP: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_n_out) |-> (pwr_en && $past(!pwr_en))); // R7

    AST_ZERO_PULSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwr_en) && pulse_ticks == '0) |-> rst_n_out); // R8

endmodule

bind hib_seq_top hib_seq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .wake_pin    (wake_pin),
    .pwr_en      (pwr_en),
    .rst_n_out   (rst_n_out),
    .cur_state   (cur_state),
    .pulse_ticks (cfg.pulse_ticks)
);

// File: tb/test_hib_seq_top.sv
module test_hib_seq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wake_pin = 1'b0;
    logic        pwr_en;
    logic        rst_n_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // filter ticks, pulse ticks, expected qualify cycles, expected pulse cycles
    localparam int VEC [7][4] = '{
        '{0,     0,    1,     0},
        '{32,    0,    32,    0},
        '{0,     32,   1,     32},
        '{32,    64,   32,    64},
        '{64,    32,   64,    32},
        '{96,    96,   96,    96},
        '{65504, 4064, 65504, 4064}
    };

    hib_seq_top i_hib_seq_top (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wake_pin  (wake_pin),
        .pwr_en    (pwr_en),
        .rst_n_out (rst_n_out)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic count_qualify(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!pwr_en && n < 70000);
    endtask

    task automatic count_pulse(output int m);
        m = 0;
        while (!rst_n_out && m < 70000) begin
            step();
            m++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n, m;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        check(pwr_en == 1'b1, "R1 pwr_en", pwr_en, 1);
        check(rst_n_out == 1'b1, "R1 rst_n_out", rst_n_out, 1);
        bus_read(8'h20, rd); check(rd == 0, "R1 state", rd, 0);
        bus_read(8'h24, rd); check(rd == 0, "R1 filter", rd, 0);
        bus_read(8'h28, rd); check(rd == 0, "R1 pulse", rd, 0);

        // Vector table walk (R2 R5 R7 R8)
        foreach (VEC[i]) begin
            bus_write(8'h24, VEC[i][0]);
            bus_write(8'h28, VEC[i][1]);
            bus_write(8'h20, 32'h1);
            check(pwr_en == 1'b0, "R2 sleep drops power", pwr_en, 0);
            bus_read(8'h20, rd); check(rd == 1, "R2 state asleep", rd, 1);
            wake_pin = 1'b1;
            count_qualify(n);
            wake_pin = 1'b0;
            check(n == VEC[i][2], "R5 qualify cycles", n, VEC[i][2]);
            count_pulse(m);
            if (VEC[i][1] == 0)
                check(m == 0, "R8 no pulse", m, 0);
            else
                check(m == VEC[i][3], "R7 pulse cycles", m, VEC[i][3]);
            check(pwr_en && rst_n_out, "R7 awake after pulse", {pwr_en, rst_n_out}, 3);
        end

        // R4 R7 field masking
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_read(8'h24, rd); check(rd == 32'h0000_FFE0, "R4 filter mask", rd, 32'hFFE0);
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_read(8'h28, rd); check(rd == 32'h0000_0FE0, "R7 pulse mask", rd, 32'h0FE0);

        // R10 unmapped read
        bus_read(8'h0C, rd); check(rd == 0, "R10 unmapped 0x0C", rd, 0);
        bus_read(8'h2C, rd); check(rd == 0, "R10 unmapped 0x2C", rd, 0);

        // R9 pin ignored while awake
        wake_pin = 1'b1;
        repeat (5) step();
        check(pwr_en && rst_n_out, "R9 pin ignored awake", {pwr_en, rst_n_out}, 3);
        bus_read(8'h20, rd); check(rd == 0, "R9 state awake", rd, 0);
        wake_pin = 1'b0;

        // R3 bit 0 clear ignored
        bus_write(8'h20, 32'h2);
        check(pwr_en == 1'b1, "R3 bit0 clear ignored", pwr_en, 1);

        // R6 glitch restarts the filter
        bus_write(8'h24, 32'd64);
        bus_write(8'h28, 32'd0);
        bus_write(8'h20, 32'h1);
        wake_pin = 1'b1;
        repeat (40) step();
        check(pwr_en == 1'b0, "R6 still asleep mid-qualify", pwr_en, 0);
        bus_read(8'h20, rd); check(rd == 2, "R6 state qualifying", rd, 2);
        wake_pin = 1'b0;
        step();
        bus_read(8'h20, rd); check(rd == 1, "R6 back to asleep", rd, 1);
        check(pwr_en == 1'b0, "R6 power stays off", pwr_en, 0);
        wake_pin = 1'b1;
        count_qualify(n);
        wake_pin = 1'b0;
        check(n == 64, "R6 full count after glitch", n, 64);

        // R3 sleep command on last pulse edge is ignored
        bus_write(8'h24, 32'd32);
        bus_write(8'h28, 32'd32);
        bus_write(8'h20, 32'h1);
        wake_pin = 1'b1;
        count_qualify(n);
        wake_pin = 1'b0;
        check(rst_n_out == 1'b0, "R7 pulse started", rst_n_out, 0);
        repeat (31) step();
        bus_read(8'h20, rd); check(rd == 3, "R7 still in pulse", rd, 3);
        bus_write(8'h20, 32'h1);
        check(pwr_en && rst_n_out, "R3 command on last pulse edge ignored", {pwr_en, rst_n_out}, 3);
        bus_read(8'h20, rd); check(rd == 0, "R3 state awake after clash", rd, 0);
        step();
        check(pwr_en == 1'b1, "R3 stays awake", pwr_en, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule